// File: doc/BRIEF.md
# IPMB Request Responder

This block sits on a byte-level two-wire bus as a management endpoint. While another node writes a request to it, the block collects the bytes as a slave. When that write closes, it assembles a fixed ten-byte completion frame, asks for the bus, and once granted acts as master to send the frame back to the node that asked.

The response echoes the requester's command and sequence number. It carries the response function code, which is the request function code plus one. It reports a success completion code and protects the header and the whole frame with two two's-complement checksums. Reads aimed at the block while it is a slave always return all-ones. A request too short to contain a command gets no reply and raises a one-cycle error pulse instead. Bit-level line signalling and arbitration belong to a neighbouring bus controller, which talks to this block through the byte strobes and the request/grant pair below.

Top module: `ipmb_responder`

## Requirements
- R1: `s_start` resets the receive count to zero. Each `s_data_vld` byte is then appended, up to RX_DEPTH (512) bytes per write; further bytes are dropped. The reply is always built from the first five bytes of the latest write, so a long write and a later short write are each judged on their own length.
- R2: `s_rd_data` is 0xFF at all times, including while a reply is in flight.
- R3: The master start addresses the 7-bit target `rq2[7:1]`, where rqN is the N-th request byte. Response byte 1 is `{rq0[7:2] + 1, 2'b00}`: the function code is incremented modulo 64 and the LUN is zero.
- R4: Response byte 2 equals `0 - (rq2 + byte1)` mod 256, and byte 9 equals `0 - (sum of bytes 0..8)` mod 256. Byte 0 is the full 8-bit `rq2` in both sums.
- R5: Response bytes 3 to 8, in order, are `own_addr`, `{rq3[7:2], 2'b00}`, `rq4`, 0x00 (success), 0x55 and 0x00.
- R6: A write of at least five bytes that closes with `s_stop` while the block is idle raises `bus_req` on the next cycle. `m_start` appears only on the cycle after `bus_gnt` was sampled high.
- R7: After `m_start` the block sends response bytes 1 to 9 on `m_data_vld`, one at a time. Each waits for an `m_ack_vld`. After the ninth acknowledge comes one `m_stop` pulse, and `bus_req` falls on the following cycle. At most one of `m_start`, `m_data_vld` and `m_stop` is high in any cycle.
- R8: An acknowledge with `m_nack` high ends the transfer: the next cycle carries `m_stop` and no further data. The following request is answered in full, from byte 1 onward.
- R9: A write closing with fewer than five bytes produces a single-cycle `short_err` one cycle after `s_stop`, and `bus_req` stays low.
- R10: A slave write that starts or ends during a reply does not change the frame being sent. A write that ends while a reply is pending or in flight gets no reply of its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| own_addr | input | 8 | Block's own slave address, placed in response byte 3 |
| s_start | input | 1 | Slave write to this block begins |
| s_data_vld | input | 1 | Slave write byte strobe |
| s_data | input | 8 | Slave write byte |
| s_stop | input | 1 | Slave write ends |
| s_rd_data | output | 8 | Byte returned for slave reads (0xFF) |
| bus_req | output | 1 | Request for master ownership of the bus |
| bus_gnt | input | 1 | Master ownership granted |
| m_start | output | 1 | Master start strobe for address `m_addr` |
| m_addr | output | 7 | Target address for the master start |
| m_data_vld | output | 1 | Master byte strobe |
| m_data | output | 8 | Master byte |
| m_ack_vld | input | 1 | Target response to the last address or byte |
| m_nack | input | 1 | Qualifies `m_ack_vld` as not-acknowledge |
| m_stop | output | 1 | Master stop strobe; the bus is released afterwards |
| short_err | output | 1 | Pulse: a request ended with fewer than five bytes |

## Verification
Slave capture and master transmission can fall in the same cycle: a new request's start, data bytes and stop may arrive while the block is sending a reply and waiting for acknowledges. The bench provokes this by running a second write, from a few cycles after the grant, alongside the acknowledge responder. It then judges three things: the reply still matches the first request byte for byte, no second bus request follows, and a later request is again answered from its own bytes.

// File: rtl/ipmb_resp_pkg.sv
// Shared constants and state encoding for the IPMB request responder.
// Assumes: frame layout is fixed at ten bytes; header needs five bytes.
package ipmb_resp_pkg;
    localparam int FRAME_LEN = 10;
    localparam int HDR_LEN   = 5;

    localparam logic [7:0] CC_SUCCESS = 8'h00;
    localparam logic [7:0] FILL_55    = 8'h55;
    localparam logic [7:0] READ_FILL  = 8'hFF;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_REQ,
        TX_ADDR,
        TX_WAIT,
        TX_DATA,
        TX_STOP
    } tx_state_e;
endpackage

// File: rtl/ipmb_rx_capture.sv
// Slave-side capture of an incoming request write.
// Counts bytes of the current write (saturating at RX_DEPTH) and keeps the
// first HDR_LEN bytes, which are all the reply needs. Flags the end of a
// write as either usable or short.
// Assumes: s_start, s_data_vld and s_stop are mutually exclusive strobes.
module ipmb_rx_capture
    import ipmb_resp_pkg::*;
#(
    parameter int RX_DEPTH = 512,
    localparam int CW = $clog2(RX_DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      s_start,
    input  logic                      s_data_vld,
    input  logic [7:0]                s_data,
    input  logic                      s_stop,
    output logic [HDR_LEN-1:0][7:0]   hdr_o,
    output logic                      good_end_o,
    output logic                      short_end_o
);
    logic [CW-1:0] rx_cnt;

    // Byte count for the current write; cleared by a new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_cnt <= '0;
        end else if (s_start) begin
            rx_cnt <= '0;
        end else if (s_data_vld && (rx_cnt < CW'(RX_DEPTH))) begin
            rx_cnt <= rx_cnt + 1'b1;
        end
    end

    // One register per header position, loaded when its byte arrives.
    for (genvar g = 0; g < HDR_LEN; g++) begin : g_hdr
        always_ff @(posedge clk) begin
            if (!rst_n || s_start) begin
                hdr_o[g] <= '0;
            end else if (s_data_vld && (rx_cnt == CW'(g))) begin
                hdr_o[g] <= s_data;
            end
        end
    end

    // End-of-write classification by captured length.
    always_comb begin
        good_end_o  = s_stop && (rx_cnt >= CW'(HDR_LEN));
        short_end_o = s_stop && (rx_cnt <  CW'(HDR_LEN));
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(RX_DEPTH));

    p_start_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_start |=> !good_end_o);
endmodule

// File: rtl/ipmb_frame_build.sv
// Combinational assembly of the ten-byte completion frame from the captured
// header. Byte 0 holds the full 8-bit requester address; the master later
// uses its upper seven bits as the target.
// Assumes: hdr_i is stable whenever the result is sampled.
module ipmb_frame_build
    import ipmb_resp_pkg::*;
(
    input  logic [HDR_LEN-1:0][7:0]   hdr_i,
    input  logic [7:0]                own_addr,
    output logic [FRAME_LEN-1:0][7:0] frame_o
);
    logic [7:0] hdr_sum;
    logic [7:0] all_sum;

    // Field placement, then two's-complement checksums over the full bytes.
    always_comb begin
        frame_o    = '0;
        frame_o[0] = hdr_i[2];
        frame_o[1] = {hdr_i[0][7:2] + 6'd1, 2'b00};
        hdr_sum    = frame_o[0] + frame_o[1];
        frame_o[2] = 8'h00 - hdr_sum;
        frame_o[3] = own_addr;
        frame_o[4] = {hdr_i[3][7:2], 2'b00};
        frame_o[5] = hdr_i[4];
        frame_o[6] = CC_SUCCESS;
        frame_o[7] = FILL_55;
        frame_o[8] = 8'h00;
        all_sum    = 8'h00;
        for (int i = 0; i < FRAME_LEN - 1; i++) begin
            all_sum = all_sum + frame_o[i];
        end
        frame_o[FRAME_LEN-1] = 8'h00 - all_sum;
    end
endmodule

// File: rtl/ipmb_tx_master.sv
// Master-side sender. Latches a frame, requests the bus, issues a start to
// the 7-bit target, then sends bytes 1..FRAME_LEN-1, each after an
// acknowledge. Any NACK or the last acknowledge leads to a stop, bus release
// and clearing of buffer and position.
// Assumes: m_ack_vld arrives only while a start or byte is outstanding.
module ipmb_tx_master
    import ipmb_resp_pkg::*;
#(
    localparam int PW = $clog2(FRAME_LEN)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic [FRAME_LEN-1:0][7:0] frame_i,
    output logic                      bus_req,
    input  logic                      bus_gnt,
    output logic                      m_start,
    output logic [6:0]                m_addr,
    output logic                      m_data_vld,
    output logic [7:0]                m_data,
    input  logic                      m_ack_vld,
    input  logic                      m_nack,
    output logic                      m_stop
);
    localparam logic [PW-1:0] LAST = PW'(FRAME_LEN - 1);

    tx_state_e                 state;
    logic [FRAME_LEN-1:0][7:0] frame_q;
    logic [PW-1:0]             pos;

    // Sequencer: request, start, byte/acknowledge loop, stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            frame_q <= '0;
            pos     <= '0;
        end else begin
            case (state)
                TX_IDLE: if (load_i) begin
                    frame_q <= frame_i;
                    pos     <= '0;
                    state   <= TX_REQ;
                end
                TX_REQ:  if (bus_gnt) state <= TX_ADDR;
                TX_ADDR: state <= TX_WAIT;
                TX_DATA: state <= TX_WAIT;
                TX_WAIT: if (m_ack_vld) begin
                    if (m_nack || pos == LAST) begin
                        state <= TX_STOP;
                    end else begin
                        pos   <= pos + 1'b1;
                        state <= TX_DATA;
                    end
                end
                TX_STOP: begin
                    frame_q <= '0;
                    pos     <= '0;
                    state   <= TX_IDLE;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // Output strobes and byte selection decoded from the sequencer.
    always_comb begin
        bus_req    = (state != TX_IDLE);
        m_start    = (state == TX_ADDR);
        m_data_vld = (state == TX_DATA);
        m_stop     = (state == TX_STOP);
        m_addr     = frame_q[0][7:1];
        m_data     = (pos <= LAST) ? frame_q[pos] : 8'h00;
    end

    p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({m_start, m_data_vld, m_stop}));

    p_start_granted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        m_start |-> $past(bus_gnt));

    p_nack_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_WAIT && m_ack_vld && m_nack) |=> m_stop);

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_stop |=> !bus_req);

    p_frame_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !m_stop) |=> $stable(frame_q));
endmodule

// File: rtl/ipmb_responder.sv
// Top of the IPMB request responder: slave capture, frame assembly and
// master sender, plus the short-request error pulse and the read fill byte.
// Assumes: a write that ends while a reply is in flight is not answered.
module ipmb_responder
    import ipmb_resp_pkg::*;
#(
    parameter int RX_DEPTH = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] own_addr,
    input  logic       s_start,
    input  logic       s_data_vld,
    input  logic [7:0] s_data,
    input  logic       s_stop,
    output logic [7:0] s_rd_data,
    output logic       bus_req,
    input  logic       bus_gnt,
    output logic       m_start,
    output logic [6:0] m_addr,
    output logic       m_data_vld,
    output logic [7:0] m_data,
    input  logic       m_ack_vld,
    input  logic       m_nack,
    output logic       m_stop,
    output logic       short_err
);
    logic [HDR_LEN-1:0][7:0]   hdr;
    logic [FRAME_LEN-1:0][7:0] frame;
    logic                      good_end;
    logic                      short_end;

    ipmb_rx_capture #(.RX_DEPTH(RX_DEPTH)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .s_start     (s_start),
        .s_data_vld  (s_data_vld),
        .s_data      (s_data),
        .s_stop      (s_stop),
        .hdr_o       (hdr),
        .good_end_o  (good_end),
        .short_end_o (short_end)
    );

    ipmb_frame_build u_build (
        .hdr_i    (hdr),
        .own_addr (own_addr),
        .frame_o  (frame)
    );

    ipmb_tx_master u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (good_end),
        .frame_i    (frame),
        .bus_req    (bus_req),
        .bus_gnt    (bus_gnt),
        .m_start    (m_start),
        .m_addr     (m_addr),
        .m_data_vld (m_data_vld),
        .m_data     (m_data),
        .m_ack_vld  (m_ack_vld),
        .m_nack     (m_nack),
        .m_stop     (m_stop)
    );

    // One-cycle error pulse for a request too short to answer.
    always_ff @(posedge clk) begin
        if (!rst_n) short_err <= 1'b0;
        else        short_err <= short_end;
    end

    assign s_rd_data = READ_FILL;

    p_req_after_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(s_stop));

    p_short_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        short_err |-> !$rose(bus_req));
endmodule

// File: tb/ipmb_responder_test.sv
`timescale 1ns/1ps
module ipmb_responder_test;
    localparam logic [7:0] OWN = 8'h2C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] own_addr = OWN;
    logic       s_start = 0, s_data_vld = 0, s_stop = 0;
    logic [7:0] s_data = 0;
    logic [7:0] s_rd_data;
    logic       bus_req, bus_gnt = 0;
    logic       m_start, m_data_vld, m_stop, short_err;
    logic [6:0] m_addr;
    logic [7:0] m_data;
    logic       m_ack_vld = 0, m_nack = 0;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    logic [7:0] rq [0:15];
    logic [7:0] ex [0:9];
    logic [7:0] got [0:15];
    logic [6:0] got_addr;
    int got_n;
    bit saw_stop;

    ipmb_responder uut (.*);

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung (act cycle %0d, exp < 150000)", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
        end
    endtask

    // Bench-side model of the completion frame.
    task automatic build_expect();
        logic [7:0] s;
        ex[0] = rq[2];
        ex[1] = {rq[0][7:2] + 6'd1, 2'b00};
        ex[2] = 8'(0 - int'(ex[0]) - int'(ex[1]));
        ex[3] = OWN;
        ex[4] = rq[3] & 8'hFC;
        ex[5] = rq[4];
        ex[6] = 8'h00; ex[7] = 8'h55; ex[8] = 8'h00;
        s = 0;
        for (int i = 0; i < 9; i++) s = s + ex[i];
        ex[9] = 8'h00 - s;
    endtask

    // Slave write of n bytes; bytes past 16 are filler. Checks R6/R9 if asked.
    task automatic send_write(input int n, input bit chk_end, input bit expect_req);
        @(negedge clk); s_start = 1;
        @(negedge clk); s_start = 0;
        for (int i = 0; i < n; i++) begin
            s_data_vld = 1; s_data = (i < 16) ? rq[i] : 8'(i);
            @(negedge clk);
        end
        s_data_vld = 0;
        s_stop = 1;
        @(negedge clk); s_stop = 0;
        if (chk_end) begin
            if (expect_req) begin
                chk(bus_req == 1, "R6 bus_req after stop", bus_req, 1);
                chk(short_err == 0, "R9 no short_err on full frame", short_err, 0);
            end else begin
                chk(short_err == 1, "R9 short_err pulse", short_err, 1);
                chk(bus_req == 0, "R9 no bus_req on short", bus_req, 0);
                @(negedge clk);
                chk(short_err == 0, "R9 short_err one cycle", short_err, 0);
            end
        end
    endtask

    // Grant the bus and acknowledge; nack_at: -1 none, 0 address, k data byte k.
    task automatic serve(input int nack_at);
        int t;
        bit pend, pend_nack, early;
        got_n = 0; saw_stop = 0; pend = 0; pend_nack = 0; early = 0; t = 0;
        while (!bus_req && t < 50) begin @(negedge clk); t++; end
        repeat (3) begin @(negedge clk); if (m_start) early = 1; end
        chk(!early, "R6 no start before grant", early, 0);
        bus_gnt = 1;
        t = 0;
        while (!saw_stop && t < 300) begin
            @(negedge clk); t++;
            if (m_ack_vld) begin
                m_ack_vld = 0; m_nack = 0;
            end else if (pend) begin
                m_ack_vld = 1; m_nack = pend_nack; pend = 0;
            end
            if (m_start) begin
                got_addr = m_addr; bus_gnt = 0; pend = 1; pend_nack = (nack_at == 0);
            end
            if (m_data_vld) begin
                got[got_n] = m_data; got_n++; pend = 1; pend_nack = (nack_at == got_n);
            end
            if (m_stop) saw_stop = 1;
        end
        chk(saw_stop, "R7 stop issued", saw_stop, 1);
        @(negedge clk);
        chk(bus_req == 0, "R7 bus released after stop", bus_req, 0);
    endtask

    task automatic check_full_reply(input string tag);
        chk(got_addr == ex[0][7:1], {tag, " R3 target address"}, got_addr, ex[0][7:1]);
        chk(got_n == 9, {tag, " R7 nine data bytes"}, got_n, 9);
        chk(got[0] == ex[1], {tag, " R3 netFn byte"}, got[0], ex[1]);
        chk(got[1] == ex[2] && got[8] == ex[9], {tag, " R4 checksums"},
            {got[1], got[8]}, {ex[2], ex[9]});
        for (int k = 3; k <= 8; k++)
            chk(got[k-1] == ex[k], {tag, " R5 body byte"}, got[k-1], ex[k]);
    endtask

    task automatic t_reset();
        chk(bus_req == 0 && short_err == 0, "R7 reset idle", {bus_req, short_err}, 0);
        chk({m_start, m_data_vld, m_stop} == 0, "R7 reset strobes", {m_start, m_data_vld, m_stop}, 0);
        chk(s_rd_data == 8'hFF, "R2 read fill at reset", s_rd_data, 8'hFF);
    endtask

    task automatic t_basic();
        rq[0] = 8'h18; rq[1] = 8'hC8; rq[2] = 8'h20; rq[3] = 8'h15; rq[4] = 8'h01; rq[5] = 8'hCA;
        build_expect();
        send_write(6, 1, 1);
        serve(-1);
        check_full_reply("basic");
    endtask

    task automatic t_wrap();
        rq[0] = 8'hFF; rq[1] = 8'h00; rq[2] = 8'hFF; rq[3] = 8'hFF; rq[4] = 8'hA7;
        build_expect();
        send_write(5, 1, 1);
        serve(-1);
        check_full_reply("wrap");
        chk(got[0] == 8'h00, "R3 netFn wraps, LUN zero", got[0], 8'h00);
    endtask

    task automatic t_nack();
        rq[0] = 8'h2C; rq[1] = 8'h00; rq[2] = 8'h34; rq[3] = 8'h41; rq[4] = 8'h55;
        build_expect();
        send_write(5, 1, 1);
        serve(0);
        chk(got_n == 0, "R8 nack on address stops", got_n, 0);
        send_write(5, 1, 1);
        serve(4);
        chk(got_n == 4, "R8 nack on byte 4 stops", got_n, 4);
        rq[4] = 8'h3E;
        build_expect();
        send_write(7, 1, 1);
        serve(-1);
        check_full_reply("after-nack R8");
    endtask

    task automatic t_short();
        rq[0] = 8'h18; rq[1] = 8'h00; rq[2] = 8'h20; rq[3] = 8'h04;
        send_write(4, 1, 0);
        send_write(0, 1, 0);
    endtask

    task automatic t_long();
        rq[0] = 8'h30; rq[1] = 8'h00; rq[2] = 8'h62; rq[3] = 8'h8B; rq[4] = 8'h20;
        build_expect();
        send_write(600, 1, 1);
        serve(-1);
        check_full_reply("long R1");
        send_write(3, 1, 0);
        chk(1'b1, "R1 count cleared by new start", 0, 0);
    endtask

    task automatic t_overlap();
        logic [7:0] keep [0:9];
        rq[0] = 8'h0C; rq[1] = 8'h00; rq[2] = 8'h42; rq[3] = 8'h09; rq[4] = 8'h77;
        build_expect();
        for (int i = 0; i < 10; i++) keep[i] = ex[i];
        send_write(5, 1, 1);
        fork
            serve(-1);
            begin
                repeat (8) @(negedge clk);
                chk(s_rd_data == 8'hFF, "R2 read fill while busy", s_rd_data, 8'hFF);
                rq[0] = 8'h44; rq[2] = 8'h90; rq[3] = 8'hF3; rq[4] = 8'h11;
                send_write(6, 0, 0);
            end
        join
        for (int i = 0; i < 10; i++) ex[i] = keep[i];
        check_full_reply("overlap R10");
        repeat (10) begin
            @(negedge clk);
            chk(bus_req == 0, "R10 no reply to write ended while busy", bus_req, 0);
        end
        rq[0] = 8'h44; rq[2] = 8'h90; rq[3] = 8'hF3; rq[4] = 8'h11;
        build_expect();
        send_write(5, 1, 1);
        serve(-1);
        check_full_reply("post-overlap R10");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_nack();
        t_short();
        t_long();
        t_overlap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule